// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns the system clock into the 16x oversampling enable that drives a UART's transmit and receive shifters. The tick rate comes from a 16-bit integer divisor and a fractional stretch. The stretch uses a 4-bit add value and a 4-bit multiply value, so the mean spacing between ticks is `divisor * (1 + add/mul)` clocks. The resulting baud rate is `f_clk / (16 * divisor * (1 + add/mul))`. This lets a fixed system clock reach standard baud rates that an integer divisor alone would miss.

Software programs the block through a small byte-wide write port. The two divisor bytes are shielded by a latch-enable bit in the line-control register, in the manner of the classic 16550 register set. The fraction register can be written at any time. Illegal settings are folded into legal ones before use: a zero divisor, a zero multiplier, an add value not below the multiplier, and a too-small divisor while the fraction is active. Every accepted divisor or fraction write restarts the tick sequence from a clean phase.

The fractional stretch is spread evenly. An accumulator gains `add` on every tick period, modulo `mul`. Each period in which the accumulator wraps lasts two divisor periods instead of one.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, `baud_tick` is low. After reset the divisor is `RESET_DL` (default 8), add = 0 and mul = 1, so ticks are spaced exactly 8 clocks apart.
- R2: Write addresses are as follows. 0 is the divisor low byte and 1 is the divisor high byte. 2 is the fraction register, with add in bits 3:0 and mul in bits 7:4; it is writable regardless of the latch bit. 3 is the line-control register, whose bit 7 is the divisor latch-enable bit.
- R3: A write to address 0 or 1 while the latch bit is 0 is ignored: the divisor keeps its value and the tick phase is not disturbed. A write to address 3 never disturbs the tick phase.
- R4: `baud_tick` is a single-cycle pulse. With add = 0 the spacing between ticks is exactly the divisor, in clocks.
- R5: A divisor of 0 behaves as a divisor of 1, which gives a tick on every clock.
- R6: When the effective add value is nonzero, a divisor below 2 is used as 2.
- R7: A mul value of 0 is used as 1. An add value greater than or equal to the effective mul is used as 0.
- R8: Each tick period is either D or 2*D clocks, where D is the effective divisor. Any run of M consecutive periods, where M is the effective mul, totals exactly D*(M+A) clocks, where A is the effective add.
- R9: An accepted write to address 0, 1 or 2 restarts the sequence. If the write is sampled at clock edge W, the first new tick is high after edge W+D+1. That first period is never stretched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (see R2) |
| wr_data | input | 8 | Register write data |
| baud_tick | output | 1 | One-clock enable at 16x the baud rate |

## Verification
The bench goes after the guard corners: divisor zero with and without an active fraction, a zero multiplier, and an add value at or above the multiplier. A design that mishandles any of these would stall, tick every clock when it should tick every other clock, or stretch periods that must stay plain. Long windows of exactly M periods are summed and compared against D*(M+A). A wrong wrap test in the accumulator would drift by whole divisor periods, so these sums expose it. The latency of the first tick after a write shows whether the restart fires. Writes to the locked divisor bytes and to the line-control register must leave the tick phase untouched; a design that restarted on them would leave a gap longer than the divisor.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int ADDR_W    = 2;
    localparam int LATCH_BIT = 7;

    // Write-port register selector
    typedef enum logic [ADDR_W-1:0] {
        REG_DIV_LO = 2'd0,
        REG_DIV_HI = 2'd1,
        REG_FRAC   = 2'd2,
        REG_LINE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
    import frac_baud_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int FRAC_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RESET_DL = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DIV_W-1:0]     dl_o,
    output logic [FRAC_W-1:0]    add_o,
    output logic [FRAC_W-1:0]    mul_o,
    output logic                 latch_o,
    output logic                 restart_o
);

    localparam int HI_W = DIV_W - DATA_W;

    typedef struct packed {
        logic [DIV_W-1:0]  dl;
        logic [FRAC_W-1:0] add;
        logic [FRAC_W-1:0] mul;
        logic              latch;
        logic              restart;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.restart = 1'b0;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_DIV_LO: begin
                    if (r_q.latch) begin
                        r_d.dl[DATA_W-1:0] = wr_data;
                        r_d.restart        = 1'b1;
                    end
                end
                REG_DIV_HI: begin
                    if (r_q.latch) begin
                        r_d.dl[DIV_W-1:DATA_W] = wr_data[HI_W-1:0];
                        r_d.restart            = 1'b1;
                    end
                end
                REG_FRAC: begin
                    r_d.add     = wr_data[FRAC_W-1:0];
                    r_d.mul     = wr_data[2*FRAC_W-1:FRAC_W];
                    r_d.restart = 1'b1;
                end
                default: begin
                    r_d.latch = wr_data[LATCH_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.dl      <= DIV_W'(RESET_DL);
            r_q.add     <= '0;
            r_q.mul     <= FRAC_W'(1);
            r_q.latch   <= 1'b0;
            r_q.restart <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dl_o      = r_q.dl;
    assign add_o     = r_q.add;
    assign mul_o     = r_q.mul;
    assign latch_o   = r_q.latch;
    assign restart_o = r_q.restart;

endmodule

// File: rtl/frac_baud_guard.sv
module frac_baud_guard #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic [DIV_W-1:0]  dl_i,
    input  logic [FRAC_W-1:0] add_i,
    input  logic [FRAC_W-1:0] mul_i,
    output logic [DIV_W-1:0]  dl_o,
    output logic [FRAC_W-1:0] add_o,
    output logic [FRAC_W-1:0] mul_o
);

    logic [DIV_W-1:0]  dl_v;
    logic [FRAC_W-1:0] add_v;
    logic [FRAC_W-1:0] mul_v;

    always_comb begin
        mul_v = (mul_i == '0) ? FRAC_W'(1) : mul_i;
        add_v = (add_i >= mul_v) ? '0 : add_i;
        dl_v  = (dl_i == '0) ? DIV_W'(1) : dl_i;
        if ((add_v != '0) && (dl_v < DIV_W'(2))) begin
            dl_v = DIV_W'(2);
        end
    end

    assign dl_o  = dl_v;
    assign add_o = add_v;
    assign mul_o = mul_v;

endmodule

// File: rtl/frac_baud_engine.sv
module frac_baud_engine #(
    parameter int DIV_W     = 16,
    parameter int FRAC_W    = 4,
    parameter int RESET_PER = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  dl_eff,
    input  logic [FRAC_W-1:0] add_eff,
    input  logic [FRAC_W-1:0] mul_eff,
    output logic              tick_o,
    output logic [DIV_W:0]    cnt_o,
    output logic [DIV_W:0]    per_o,
    output logic [FRAC_W-1:0] acc_o
);

    localparam int PER_W = DIV_W + 1;

    typedef struct packed {
        logic [PER_W-1:0]  cnt;
        logic [PER_W-1:0]  per;
        logic [FRAC_W-1:0] acc;
        logic              tick;
    } eng_t;

    eng_t s_d, s_q;

    logic [FRAC_W:0]  sum;
    logic             wrap;
    logic [PER_W-1:0] base;

    always_comb begin
        sum  = {1'b0, s_q.acc} + {1'b0, add_eff};
        wrap = (sum >= {1'b0, mul_eff});
        base = {1'b0, dl_eff};

        s_d      = s_q;
        s_d.tick = 1'b0;
        if (restart) begin
            s_d.cnt = '0;
            s_d.acc = add_eff;
            s_d.per = base;
        end else if (s_q.cnt == (s_q.per - PER_W'(1))) begin
            s_d.tick = 1'b1;
            s_d.cnt  = '0;
            if (wrap) begin
                s_d.acc = FRAC_W'(sum - {1'b0, mul_eff});
                s_d.per = {dl_eff, 1'b0};
            end else begin
                s_d.acc = sum[FRAC_W-1:0];
                s_d.per = base;
            end
        end else begin
            s_d.cnt = s_q.cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.per  <= PER_W'(RESET_PER);
            s_q.acc  <= '0;
            s_q.tick <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = s_q.tick;
    assign cnt_o  = s_q.cnt;
    assign per_o  = s_q.per;
    assign acc_o  = s_q.acc;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int FRAC_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RESET_DL = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                baud_tick
);

    localparam int RESET_PER = (RESET_DL == 0) ? 1 : RESET_DL;

    logic [DIV_W-1:0]  dl_raw;
    logic [FRAC_W-1:0] add_raw;
    logic [FRAC_W-1:0] mul_raw;
    logic              latch_w;
    logic              restart_w;
    logic [DIV_W-1:0]  dl_eff;
    logic [FRAC_W-1:0] add_eff;
    logic [FRAC_W-1:0] mul_eff;
    logic [DIV_W:0]    cnt_w;
    logic [DIV_W:0]    per_w;
    logic [FRAC_W-1:0] acc_w;

    frac_baud_regs #(
        .DIV_W    (DIV_W),
        .FRAC_W   (FRAC_W),
        .DATA_W   (DATA_W),
        .RESET_DL (RESET_DL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dl_o      (dl_raw),
        .add_o     (add_raw),
        .mul_o     (mul_raw),
        .latch_o   (latch_w),
        .restart_o (restart_w)
    );

    frac_baud_guard #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W)
    ) u_guard (
        .dl_i  (dl_raw),
        .add_i (add_raw),
        .mul_i (mul_raw),
        .dl_o  (dl_eff),
        .add_o (add_eff),
        .mul_o (mul_eff)
    );

    frac_baud_engine #(
        .DIV_W     (DIV_W),
        .FRAC_W    (FRAC_W),
        .RESET_PER (RESET_PER)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_w),
        .dl_eff  (dl_eff),
        .add_eff (add_eff),
        .mul_eff (mul_eff),
        .tick_o  (baud_tick),
        .cnt_o   (cnt_w),
        .per_o   (per_w),
        .acc_o   (acc_w)
    );

endmodule

// File: rtl/frac_baud_checker.sv
module frac_baud_checker
    import frac_baud_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              latch,
    input logic              restart,
    input logic [DIV_W-1:0]  dl,
    input logic [DIV_W-1:0]  dl_eff,
    input logic [FRAC_W-1:0] add_eff,
    input logic [FRAC_W-1:0] mul_eff,
    input logic [DIV_W:0]    cnt,
    input logic [DIV_W:0]    per,
    input logic [FRAC_W-1:0] acc,
    input logic              tick
);

    logic locked_div_wr;
    assign locked_div_wr = wr_en && !latch &&
                           ((wr_addr == REG_DIV_LO) || (wr_addr == REG_DIV_HI));

    AST_LOCKED_DIV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        locked_div_wr |=> ($stable(dl) && !restart)); // R3

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (per >= 2)) |=> !tick); // R4

    AST_DL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dl_eff != '0); // R5

    AST_FRAC_DL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (add_eff != '0) |-> (dl_eff >= 2)); // R6

    AST_ADD_BELOW_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_eff != '0) && (add_eff < mul_eff)); // R7

    AST_PERIOD_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> ((per == {1'b0, dl_eff}) || (per == {dl_eff, 1'b0}))); // R8

    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (acc < mul_eff)); // R8

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ((cnt == '0) && !tick)); // R9

endmodule

bind frac_baud_gen frac_baud_checker #(
    .DIV_W  (DIV_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .latch   (latch_w),
    .restart (restart_w),
    .dl      (dl_raw),
    .dl_eff  (dl_eff),
    .add_eff (add_eff),
    .mul_eff (mul_eff),
    .cnt     (cnt_w),
    .per     (per_w),
    .acc     (acc_w),
    .tick    (baud_tick)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;

    localparam logic [1:0] A_LO   = 2'd0;
    localparam logic [1:0] A_HI   = 2'd1;
    localparam logic [1:0] A_FRAC = 2'd2;
    localparam logic [1:0] A_LINE = 2'd3;

    typedef struct packed {
        logic [15:0] dl;
        logic [7:0]  frac;
        logic [15:0] eff;
        logic [7:0]  mulc;
        logic [15:0] win;
    } vec_t;

    // divisor, fraction byte, effective divisor, effective mul, sum over mul periods
    localparam vec_t VECS [0:10] = '{
        '{16'd5,   8'h10, 16'd5,   8'd1,  16'd5},
        '{16'd3,   8'h31, 16'd3,   8'd3,  16'd12},
        '{16'd260, 8'h10, 16'd260, 8'd1,  16'd260},
        '{16'd0,   8'h10, 16'd1,   8'd1,  16'd1},
        '{16'd1,   8'h21, 16'd2,   8'd2,  16'd6},
        '{16'd0,   8'h53, 16'd2,   8'd5,  16'd16},
        '{16'd4,   8'h00, 16'd4,   8'd1,  16'd4},
        '{16'd4,   8'h35, 16'd4,   8'd3,  16'd12},
        '{16'd7,   8'hF7, 16'd7,   8'd15, 16'd154},
        '{16'd2,   8'hFE, 16'd2,   8'd15, 16'd58},
        '{16'd1,   8'h03, 16'd1,   8'd1,  16'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       baud_tick;

    int     tests = 0;
    int     fails = 0;
    bit     done = 1'b0;
    longint cyc = 0;
    longint tcount = 0;
    longint tbuf [0:255];

    frac_baud_gen u_frac_baud_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .baud_tick (baud_tick)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && baud_tick) begin
            tbuf[tcount % 256] = cyc;
            tcount = tcount + 1;
        end
    end

    function automatic longint tk(input longint i);
        return tbuf[i % 256];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, output longint c);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        c     = cyc;
        wr_en = 1'b0;
    endtask

    task automatic wait_ticks(input longint target);
        while (tcount < target) @(posedge clk);
        #1;
    endtask

    task automatic first_after(input longint from, input longint after, output longint k);
        k = from;
        while (tk(k) <= after) k++;
    endtask

    task automatic run_vec(input vec_t v);
        longint c, wc, base, k, d;
        bit     ok;
        int     m;
        m = int'(v.mulc);
        wr(A_LINE, 8'h80, c);
        wr(A_LO, v.dl[7:0], c);
        wr(A_HI, v.dl[15:8], c);
        base = tcount;
        wr(A_FRAC, v.frac, wc);
        wr(A_LINE, 8'h00, c);
        wait_ticks(base + 2 * m + 8);
        first_after(base, wc, k);
        chk(tk(k) - wc == longint'(v.eff) + 1, "R9", "first tick latency",
            tk(k) - wc, longint'(v.eff) + 1);
        ok = 1'b1;
        d  = 0;
        for (int i = 0; i < 2 * m; i++) begin
            d = tk(k + i + 1) - tk(k + i);
            if (d != longint'(v.eff) && d != 2 * longint'(v.eff)) ok = 1'b0;
        end
        chk(ok, "R8", "period is D or 2D", d, longint'(v.eff));
        chk(tk(k + m) - tk(k) == longint'(v.win), "R8", "first window sum",
            tk(k + m) - tk(k), longint'(v.win));
        chk(tk(k + 2 * m) - tk(k + m) == longint'(v.win), "R8", "second window sum",
            tk(k + 2 * m) - tk(k + m), longint'(v.win));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        longint c, wc, base, k, last;
        bit     seen;

        // R1: tick stays low during reset
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (baud_tick) seen = 1'b1;
        end
        chk(!seen, "R1", "tick during reset", longint'(seen), 0);
        rst_n = 1'b1;

        // R1: default spacing after reset is 8
        base = tcount;
        wait_ticks(base + 3);
        chk(tk(base + 1) - tk(base) == 8, "R1", "reset period",
            tk(base + 1) - tk(base), 8);
        chk(tk(base + 2) - tk(base + 1) == 8, "R1", "reset period repeat",
            tk(base + 2) - tk(base + 1), 8);

        // table walk over divisor / fraction patterns
        for (int i = 0; i < 11; i++) run_vec(VECS[i]);

        // R4: single-cycle pulse at divisor 5
        wr(A_LINE, 8'h80, c);
        wr(A_LO, 8'd5, c);
        wr(A_HI, 8'd0, c);
        wr(A_FRAC, 8'h10, c);
        wr(A_LINE, 8'h00, c);
        @(negedge clk);
        while (!baud_tick) @(negedge clk);
        @(negedge clk);
        chk(!baud_tick, "R4", "pulse width", longint'(baud_tick), 0);
        base = tcount;
        wait_ticks(base + 3);
        chk(tk(base + 1) - tk(base) == 5, "R4", "integer spacing",
            tk(base + 1) - tk(base), 5);

        // R3: locked divisor writes and line writes keep phase and value
        wr(A_LINE, 8'h80, c);
        wr(A_LO, 8'd10, c);
        wr(A_LINE, 8'h00, c);
        base = tcount;
        wait_ticks(base + 2);
        last = tk(tcount - 1);
        repeat (3) @(posedge clk);
        wr(A_LO, 8'd3, c);
        wr(A_HI, 8'd1, c);
        wr(A_LINE, 8'h00, wc);
        base = tcount;
        wait_ticks(base + 4);
        first_after(base - 1, wc, k);
        chk(tk(k) - tk(k - 1) == 10, "R3", "phase kept across locked writes",
            tk(k) - tk(k - 1), 10);
        chk(tk(k + 1) - tk(k) == 10, "R3", "divisor kept after locked writes",
            tk(k + 1) - tk(k), 10);
        chk(last <= tk(k), "R3", "tick order", last, tk(k));

        // R2: fraction register is writable with the latch cleared; add 1 mul 2
        base = tcount;
        wr(A_FRAC, 8'h21, wc);
        wait_ticks(base + 8);
        first_after(base, wc, k);
        chk(tk(k + 2) - tk(k) == 30, "R2", "fraction fields with latch clear",
            tk(k + 2) - tk(k), 30);

        // R7: mul 0 with add 0 is pure integer division
        base = tcount;
        wr(A_FRAC, 8'h00, wc);
        wait_ticks(base + 6);
        first_after(base, wc, k);
        chk(tk(k + 1) - tk(k) == 10, "R7", "zero mul as one",
            tk(k + 1) - tk(k), 10);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule